// File: doc/BRIEF.md
# SMBus Byte-Data Host Controller

This block is a host-side SMBus master with a small register file on an 8-bit host bus. Software loads a slave address with a direction bit, a command byte and a data byte. It then writes the control register with the byte-data protocol code and the start bit set. The block drives open-drain clock and data lines through the whole transaction on the wire. When the transaction ends, it reports success or a device error in a status register whose flags are cleared by writing ones.

A write transaction sends the address with the direction bit low, then the command byte and the data byte, and closes with a stop. A read transaction sends the address with the direction bit low and then the command byte. It follows with a repeated start and the address with the direction bit high, receives one byte into data0, answers it with a not-acknowledge and closes with a stop. When a slave does not acknowledge at any phase, the transfer is cut short with a stop and the error flag is raised. An optional level interrupt follows the completion flags. Software can also poll the status register instead.

Top module: `smbh_host`

## Requirements
- R1: After reset every register reads 0, both bus lines are released (scl_oe and sda_oe low) and irq is low.
- R2: Status bit 0 (busy) reads 1 from the clock edge that accepts a start until the stop has completed. It clears on the same edge that sets status bit 1 or bit 2.
- R3: With transmit-address bit 0 at 0, a start sends three bytes on the wire: {addr[7:1],0}, the command byte and data0. It then sends a stop. A fully acknowledged transfer leaves status at 0x02.
- R4: With transmit-address bit 0 at 1, a start sends {addr[7:1],0} and the command byte, then a repeated start and {addr[7:1],1}. It then loads the received byte into data0 and sends a stop. A good transfer leaves status at 0x02.
- R5: When a slave does not acknowledge an address, command or data byte, status bit 2 is set, bit 1 stays clear, a stop is sent and busy clears. A failed read leaves data0 unchanged.
- R6: Writing to status (offset 0x0) clears bit 1 and bit 2 where the written value has a 1. Bits written as 0 keep their value. If completion and clearing fall on the same edge, completion wins.
- R7: irq equals control bit 0 AND (status bit 1 OR status bit 2). With control bit 0 at 0, irq stays low.
- R8: The control register (offset 0x2) holds enable in bit 0 and the protocol code in bits 4:2. Bit 6 is the start bit and always reads 0. A start is accepted only when bits 4:2 written with it equal 2 (byte-data). Any other code only stores the field and causes no bus activity.
- R9: While busy, a start is ignored. Writes to the command (0x3), transmit-address (0x4), data0 (0x5) and data1 (0x6) registers and to control bits 4:2 are also ignored.
- R10: Consecutive SCL rising edges within a transaction are exactly SCL_DIV clocks apart. SDA changes while SCL is high only for a start, a repeated start or a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe; rdata is valid the cycle after |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered on rd |
| irq | output | 1 | Level completion interrupt |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Sensed level of SDA |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench runs a behavioural slave on the wire. It drives a back-to-back write and read to the same command. A wrong direction bit during the repeated start would return a byte other than the one just written, and a missing repeated start would show as one start/stop edge too few. Refused acknowledges at the address phase and at the data phase must produce the error code with the stop still on the wire and data0 unchanged. A controller that kept going would report success or hang the bus low. The bench also sends a start with a bad protocol code and a second start while busy. Either one launching a transfer would change the count of SCL edges or stops. Measured SCL edge spacing catches any idle hand-over cycle between bits.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam logic [3:0] REG_STAT = 4'h0;
    localparam logic [3:0] REG_CTL  = 4'h2;
    localparam logic [3:0] REG_CMD  = 4'h3;
    localparam logic [3:0] REG_XA   = 4'h4;
    localparam logic [3:0] REG_D0   = 4'h5;
    localparam logic [3:0] REG_D1   = 4'h6;

    localparam logic [2:0] PROT_BDATA = 3'd2;

    typedef enum logic [1:0] {OP_START, OP_STOP, OP_WR, OP_RD} bit_op_e;

    typedef struct packed {
        bit_op_e op;
        logic    din;
    } bit_cmd_t;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR, S_CMD, S_RSTART,
        S_RADDR, S_RDATA, S_WDATA, S_STOP
    } seq_st_e;

    // {scl, sda} levels for each quarter of one bit slot
    function automatic logic [1:0] quarter_lines(bit_op_e op, logic din, logic [1:0] qtr);
        logic scl_hi;
        scl_hi = (qtr == 2'd1) || (qtr == 2'd2);
        case (op)
            OP_START: quarter_lines = {scl_hi, (qtr < 2'd2)};
            OP_STOP:  quarter_lines = {(qtr != 2'd0), (qtr >= 2'd2)};
            OP_WR:    quarter_lines = {scl_hi, din};
            default:  quarter_lines = {scl_hi, 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/smbh_bit.sv
module smbh_bit
    import smbh_pkg::*;
#(
    parameter int SCL_DIV = 40
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  bit_op_e op,
    input  logic    din,
    input  logic    sda_i,
    output logic    done,
    output logic    rx,
    output logic    scl_oe,
    output logic    sda_oe
);
    localparam int QW = SCL_DIV / 4;
    localparam int CW = (QW > 1) ? $clog2(QW) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(QW - 1);

    typedef struct packed {
        logic          active;
        bit_op_e       op;
        logic          din;
        logic [1:0]    qtr;
        logic [CW-1:0] cnt;
        logic          scl;
        logic          sda;
        logic          samp;
    } bit_state_t;

    localparam bit_state_t BIT_RST = '{active: 1'b0, op: OP_STOP, din: 1'b1, qtr: 2'd0,
                                       cnt: '0, scl: 1'b1, sda: 1'b1, samp: 1'b1};

    bit_state_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        done = 1'b0;
        if (r_q.active) begin
            if (r_q.cnt == CNT_LAST) begin
                r_d.cnt = '0;
                if (r_q.qtr == 2'd1) r_d.samp = sda_i;
                if (r_q.qtr == 2'd3) begin
                    r_d.active = 1'b0;
                    done       = 1'b1;
                end else begin
                    r_d.qtr = r_q.qtr + 2'd1;
                    {r_d.scl, r_d.sda} = quarter_lines(r_q.op, r_q.din, r_q.qtr + 2'd1);
                end
            end else begin
                r_d.cnt = r_q.cnt + CW'(1);
            end
        end
        if (go) begin
            r_d.active = 1'b1;
            r_d.op     = op;
            r_d.din    = din;
            r_d.qtr    = 2'd0;
            r_d.cnt    = '0;
            {r_d.scl, r_d.sda} = quarter_lines(op, din, 2'd0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= BIT_RST;
        else        r_q <= r_d;
    end

    assign rx     = r_q.samp;
    assign scl_oe = !r_q.scl;
    assign sda_oe = !r_q.sda;

endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
    import smbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] xa,
    input  logic [7:0] cmdb,
    input  logic [7:0] wbyte,
    input  logic       bit_done,
    input  logic       bit_rx,
    output logic       bit_go,
    output bit_op_e    bit_op,
    output logic       bit_din,
    output logic       busy,
    output logic       fin_ok,
    output logic       fin_err,
    output logic       rx_ld,
    output logic [7:0] rx_byte
);
    typedef struct packed {
        seq_st_e    st;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       err;
    } seq_state_t;

    localparam seq_state_t SEQ_RST = '{st: S_IDLE, bitn: 4'd0, sh: 8'h00, err: 1'b0};

    seq_state_t r_q, r_d;
    logic       step;
    bit_cmd_t   nxt;

    function automatic bit_cmd_t step_cmd(seq_st_e st, logic [3:0] bn, logic [7:0] sh);
        bit_cmd_t c;
        case (st)
            S_START, S_RSTART: c = '{op: OP_START, din: 1'b1};
            S_STOP:            c = '{op: OP_STOP,  din: 1'b1};
            S_RDATA:           c = (bn < 4'd8) ? '{op: OP_RD, din: 1'b1} : '{op: OP_WR, din: 1'b1};
            default:           c = (bn < 4'd8) ? '{op: OP_WR, din: sh[7]} : '{op: OP_RD, din: 1'b1};
        endcase
        return c;
    endfunction

    always_comb begin
        r_d     = r_q;
        step    = 1'b0;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        rx_ld   = 1'b0;
        if (r_q.st == S_IDLE) begin
            if (start) begin
                r_d.st   = S_START;
                r_d.err  = 1'b0;
                r_d.bitn = 4'd0;
                step     = 1'b1;
            end
        end else if (bit_done) begin
            step     = 1'b1;
            r_d.bitn = r_q.bitn + 4'd1;
            case (r_q.st)
                S_START: begin
                    r_d.st = S_ADDR; r_d.sh = {xa[7:1], 1'b0}; r_d.bitn = 4'd0;
                end
                S_RSTART: begin
                    r_d.st = S_RADDR; r_d.sh = {xa[7:1], 1'b1}; r_d.bitn = 4'd0;
                end
                S_STOP: begin
                    r_d.st  = S_IDLE;
                    fin_ok  = !r_q.err;
                    fin_err = r_q.err;
                end
                S_RDATA: begin
                    if (r_q.bitn < 4'd8) begin
                        r_d.sh = {r_q.sh[6:0], bit_rx};
                    end else begin
                        rx_ld  = 1'b1;
                        r_d.st = S_STOP;
                    end
                end
                default: begin
                    if (r_q.bitn < 4'd8) begin
                        r_d.sh = {r_q.sh[6:0], 1'b0};
                    end else if (bit_rx) begin
                        r_d.err = 1'b1;
                        r_d.st  = S_STOP;
                    end else begin
                        r_d.bitn = 4'd0;
                        case (r_q.st)
                            S_ADDR:  begin r_d.st = S_CMD; r_d.sh = cmdb; end
                            S_CMD:   begin
                                if (xa[0]) r_d.st = S_RSTART;
                                else begin r_d.st = S_WDATA; r_d.sh = wbyte; end
                            end
                            S_RADDR: r_d.st = S_RDATA;
                            default: r_d.st = S_STOP;
                        endcase
                    end
                end
            endcase
        end
        nxt     = step_cmd(r_d.st, r_d.bitn, r_d.sh);
        bit_go  = step && (r_d.st != S_IDLE);
        bit_op  = nxt.op;
        bit_din = nxt.din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_RST;
        else        r_q <= r_d;
    end

    assign busy    = (r_q.st != S_IDLE);
    assign rx_byte = r_q.sh;

endmodule

// File: rtl/smbh_host.sv
module smbh_host
    import smbh_pkg::*;
#(
    parameter int SCL_DIV = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] addr,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       scl_oe,
    input  logic       sda_i,
    output logic       sda_oe
);
    typedef struct packed {
        logic       f_done;
        logic       f_err;
        logic       ien;
        logic [2:0] prot;
        logic [7:0] cmdb;
        logic [7:0] xa;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] rdata;
    } reg_state_t;

    reg_state_t r_q, r_d;

    logic       busy, fin_ok, fin_err, rx_ld, start;
    logic [7:0] rx_byte;
    logic       bit_go, bit_din, bit_done, bit_rx;
    bit_op_e    bit_op;
    logic       flag_done, flag_err, ien;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (wr) begin
            case (addr)
                REG_STAT: begin
                    if (wdata[1]) r_d.f_done = 1'b0;
                    if (wdata[2]) r_d.f_err  = 1'b0;
                end
                REG_CTL: begin
                    r_d.ien = wdata[0];
                    if (!busy) begin
                        r_d.prot = wdata[4:2];
                        start    = wdata[6] && (wdata[4:2] == PROT_BDATA);
                    end
                end
                REG_CMD: if (!busy) r_d.cmdb = wdata;
                REG_XA:  if (!busy) r_d.xa   = wdata;
                REG_D0:  if (!busy) r_d.d0   = wdata;
                REG_D1:  if (!busy) r_d.d1   = wdata;
                default: ;
            endcase
        end
        if (rx_ld)   r_d.d0     = rx_byte;
        if (fin_ok)  r_d.f_done = 1'b1;
        if (fin_err) r_d.f_err  = 1'b1;
        if (rd) begin
            case (addr)
                REG_STAT: r_d.rdata = {5'b0, r_q.f_err, r_q.f_done, busy};
                REG_CTL:  r_d.rdata = {3'b0, r_q.prot, 1'b0, r_q.ien};
                REG_CMD:  r_d.rdata = r_q.cmdb;
                REG_XA:   r_d.rdata = r_q.xa;
                REG_D0:   r_d.rdata = r_q.d0;
                REG_D1:   r_d.rdata = r_q.d1;
                default:  r_d.rdata = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flag_done = r_q.f_done;
    assign flag_err  = r_q.f_err;
    assign ien       = r_q.ien;
    assign rdata     = r_q.rdata;
    assign irq       = r_q.ien && (r_q.f_done || r_q.f_err);

    smbh_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .xa(r_q.xa), .cmdb(r_q.cmdb), .wbyte(r_q.d0),
        .bit_done(bit_done), .bit_rx(bit_rx),
        .bit_go(bit_go), .bit_op(bit_op), .bit_din(bit_din),
        .busy(busy), .fin_ok(fin_ok), .fin_err(fin_err),
        .rx_ld(rx_ld), .rx_byte(rx_byte)
    );

    smbh_bit #(.SCL_DIV(SCL_DIV)) u_bit (
        .clk(clk), .rst_n(rst_n), .go(bit_go), .op(bit_op), .din(bit_din),
        .sda_i(sda_i), .done(bit_done), .rx(bit_rx),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

endmodule

// File: rtl/smbh_host_chk.sv
module smbh_host_chk
    import smbh_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr,
    input logic [3:0] addr,
    input logic [7:0] wdata,
    input logic       busy,
    input logic       st_done,
    input logic       st_err,
    input logic       ien,
    input logic       irq,
    input logic       scl_oe,
    input logic       sda_oe
);
    a_r2_busy_ends_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (st_done || st_err));

    a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr && (addr == REG_CTL) && wdata[6] && (wdata[4:2] == PROT_BDATA)));

    a_r5_err_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_err) |-> (!busy && $past(busy)));

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);

    a_r1_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    a_r10_sda_moves_only_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe))) |-> busy);

endmodule

bind smbh_host smbh_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .busy(busy), .st_done(flag_done), .st_err(flag_err), .ien(ien),
    .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/sim_smbh_host.sv
`timescale 1ns/1ps
module sim_smbh_host;
    localparam int SCL_DIV = 40;
    localparam logic [6:0] SLV = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, scl_oe, sda_oe;
    logic       s_drv = 1'b0;
    wire        scl_w = !scl_oe;
    wire        sda_w = !(sda_oe || s_drv);

    int errors = 0, checks = 0, cyc = 0;
    bit fin = 1'b0;

    // slave model state
    bit         p_scl = 1'b1, p_sda = 1'b1, s_act = 1'b0, s_tx = 1'b0, s_ptx = 1'b0, lr_ok = 1'b0;
    int         s_bc = 0, s_idx = 0, nack_idx = -1;
    logic [7:0] s_sh = '0, s_cmd = '0, s_out = '0;
    logic [7:0] mem [16];
    logic [7:0] rec [8];
    int         recn = 0, stops = 0, hi_chg = 0, sclf = 0, last_rise = 0, gmin = 0, gmax = 0;

    smbh_host #(.SCL_DIV(SCL_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
        .rdata(rdata), .irq(irq), .scl_oe(scl_oe), .sda_i(sda_w), .sda_oe(sda_oe)
    );

    always #2.5 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial for (int i = 0; i < 16; i++) mem[i] = 8'h5A ^ 8'(i * 19);

    always @(negedge clk) begin
        bit sc, sd, ack;
        sc = scl_w; sd = sda_w;
        if (p_scl && sc && p_sda && !sd) begin
            s_act = 1; s_bc = 0; s_idx = 0; s_tx = 0; s_ptx = 0; s_drv = 0; hi_chg++;
        end else if (p_scl && sc && !p_sda && sd) begin
            s_act = 0; s_drv = 0; stops++; hi_chg++; lr_ok = 0;
        end else if (sc && !p_scl) begin
            if (lr_ok) begin
                if (cyc - last_rise < gmin) gmin = cyc - last_rise;
                if (cyc - last_rise > gmax) gmax = cyc - last_rise;
            end
            last_rise = cyc; lr_ok = 1;
            if (s_act) begin
                if (!s_tx && s_bc < 8) s_sh = {s_sh[6:0], sd};
                s_bc++;
            end
        end else if (!sc && p_scl) begin
            sclf++;
            if (s_act) begin
                if (s_bc == 8) begin
                    if (s_tx) s_drv = 0;
                    else begin
                        if (recn < 8) rec[recn] = s_sh;
                        recn++;
                        if (s_idx == 0) begin ack = (s_sh[7:1] == SLV); s_ptx = s_sh[0]; end
                        else begin
                            ack = 1;
                            if (s_idx == 1) s_cmd = s_sh; else mem[s_cmd[3:0]] = s_sh;
                        end
                        if (s_idx == nack_idx) ack = 0;
                        s_drv = ack;
                        if (!ack) s_act = 0;
                    end
                end else if (s_bc == 9) begin
                    s_bc = 0; s_idx++; s_tx = s_ptx; s_ptx = 0;
                    if (s_tx) begin s_out = mem[s_cmd[3:0]]; s_drv = !s_out[7]; end
                    else s_drv = 0;
                end else if (s_tx && s_bc > 0 && s_bc < 8) begin
                    s_drv = !s_out[7 - s_bc];
                end
            end
        end
        p_scl = sc; p_sda = sd;
    end

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic reg_wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic reg_rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic wait_done();
        logic [7:0] s;
        for (int i = 0; i < 5000; i++) begin
            reg_rd(4'h0, s);
            if (!s[0]) return;
        end
        check("R2 busy never cleared", 1, 0);
    endtask

    task automatic clear_all();
        reg_wr(4'h0, 8'h06);
        recn = 0; nack_idx = -1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_rd(4'h0, v); check("R1 status", v, 8'h00);
        reg_rd(4'h2, v); check("R1 control", v, 8'h00);
        reg_rd(4'h5, v); check("R1 data0", v, 8'h00);
        check("R1 lines", {scl_oe, sda_oe, irq}, 0);
    endtask

    task automatic t_write();
        logic [7:0] v;
        int s0, h0;
        clear_all();
        reg_wr(4'h4, {SLV, 1'b0}); reg_wr(4'h3, 8'h03); reg_wr(4'h5, 8'h96);
        s0 = stops; h0 = hi_chg; gmin = 99999; gmax = 0;
        reg_wr(4'h2, 8'h48);
        reg_rd(4'h0, v); check("R2 busy after start", v[0], 1);
        wait_done();
        reg_rd(4'h0, v); check("R3 write status", v, 8'h02);
        check("R3 bytes seen", recn, 3);
        check("R3 addr byte", rec[0], {SLV, 1'b0});
        check("R3 cmd byte", rec[1], 8'h03);
        check("R3 data byte", rec[2], 8'h96);
        check("R3 stop", stops - s0, 1);
        check("R10 scl spacing min", gmin, SCL_DIV);
        check("R10 scl spacing max", gmax, SCL_DIV);
        check("R10 sda edges with scl high (write)", hi_chg - h0, 2);
    endtask

    task automatic t_read();
        logic [7:0] v;
        int h0;
        clear_all();
        reg_wr(4'h4, {SLV, 1'b1}); reg_wr(4'h3, 8'h03); reg_wr(4'h5, 8'h00);
        h0 = hi_chg;
        reg_wr(4'h2, 8'h48);
        wait_done();
        reg_rd(4'h0, v); check("R4 read status", v, 8'h02);
        reg_rd(4'h5, v); check("R4 data0", v, 8'h96);
        check("R4 bytes to slave", recn, 3);
        check("R4 first addr", rec[0], {SLV, 1'b0});
        check("R4 cmd", rec[1], 8'h03);
        check("R4 second addr", rec[2], {SLV, 1'b1});
        check("R10 sda edges with scl high (read)", hi_chg - h0, 3);
        clear_all();
        reg_wr(4'h3, 8'h07);
        reg_wr(4'h2, 8'h48);
        wait_done();
        reg_rd(4'h5, v); check("R4 data0 second read", v, 8'h5A ^ 8'(7 * 19));
    endtask

    task automatic t_nack();
        logic [7:0] v;
        int s0;
        clear_all();
        reg_wr(4'h5, 8'hC3);
        reg_wr(4'h4, {7'h11, 1'b1});
        s0 = stops;
        reg_wr(4'h2, 8'h48);
        wait_done();
        reg_rd(4'h0, v); check("R5 addr nack status", v, 8'h04);
        reg_rd(4'h5, v); check("R5 data0 unchanged", v, 8'hC3);
        check("R5 stop after addr nack", stops - s0, 1);
        check("R5 only addr sent", recn, 1);
        clear_all();
        nack_idx = 2;
        reg_wr(4'h4, {SLV, 1'b0}); reg_wr(4'h3, 8'h05); reg_wr(4'h5, 8'h11);
        s0 = stops;
        reg_wr(4'h2, 8'h48);
        wait_done();
        reg_rd(4'h0, v); check("R5 data nack status", v, 8'h04);
        check("R5 stop after data nack", stops - s0, 1);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        reg_wr(4'h0, 8'h00);
        reg_rd(4'h0, v); check("R6 zero write keeps", v, 8'h04);
        reg_wr(4'h0, 8'h02);
        reg_rd(4'h0, v); check("R6 other bit keeps", v, 8'h04);
        reg_wr(4'h0, 8'h04);
        reg_rd(4'h0, v); check("R6 clear", v, 8'h00);
    endtask

    task automatic t_irq();
        clear_all();
        reg_wr(4'h4, {SLV, 1'b0});
        reg_wr(4'h2, 8'h48);
        wait_done();
        @(negedge clk); check("R7 irq off when disabled", irq, 0);
        reg_wr(4'h2, 8'h01);
        @(negedge clk); check("R7 irq on when enabled", irq, 1);
        reg_wr(4'h0, 8'h02);
        @(negedge clk); check("R7 irq after clear", irq, 0);
        reg_wr(4'h2, 8'h00);
    endtask

    task automatic t_prot();
        logic [7:0] v;
        int f0;
        clear_all();
        f0 = sclf;
        reg_wr(4'h2, 8'h4D);
        reg_rd(4'h0, v); check("R8 bad protocol not busy", v[0], 0);
        repeat (200) @(negedge clk);
        check("R8 no scl activity", sclf - f0, 0);
        reg_rd(4'h2, v); check("R8 control readback", v, 8'h0D);
        reg_wr(4'h2, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        int s0;
        clear_all();
        reg_wr(4'h4, {SLV, 1'b0}); reg_wr(4'h3, 8'h09); reg_wr(4'h5, 8'h44);
        s0 = stops;
        reg_wr(4'h2, 8'h48);
        reg_wr(4'h3, 8'h77);
        reg_wr(4'h2, 8'h4C);
        reg_rd(4'h3, v); check("R9 cmd frozen", v, 8'h09);
        reg_rd(4'h2, v); check("R9 protocol frozen", v, 8'h08);
        wait_done();
        repeat (300) @(negedge clk);
        check("R9 one transfer only", stops - s0, 1);
        check("R9 cmd on wire", rec[1], 8'h09);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_read();
        t_nack();
        t_w1c();
        t_irq();
        t_prot();
        t_busy();
        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            errors++; checks++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule